// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Error Tags

This block recovers characters from an asynchronous serial line. A one-cycle oversampling strobe (`tick`, nominally sixteen per bit time) paces it. The serial input is expected to be synchronized already. The receiver hunts for a falling edge, confirms it halfway into the start bit, then samples each following bit at the middle of its bit period. Data bits arrive least significant bit first.

Four configuration inputs set the character format: the number of data bits, whether a parity bit follows, the parity sense, and forced parity. These inputs are the same ones the companion transmitter uses. Each finished character is presented for one clock cycle on a valid strobe, which feeds a downstream FIFO. The data is right-aligned. Three tags travel with it: parity error, framing error and break.

A line held low for a whole character is reported as a break. A break is a 00 character with the break tag set. After a break, the receiver does not hunt again until the line has returned high.

Top module: `serial_rx_tagger`

## Requirements
- R1: While `rst` is high and after it falls with the line idle high, `rx_valid` stays 0.
- R2: `cfg_len` selects the data bit count: 00=5, 01=6, 10=7, 11=8. Bits are taken least significant first and placed right-aligned in `rx_data`, with unused upper bits 0.
- R3: With `cfg_par_en`=1 and `cfg_par_force`=0, the bit after the data is compared with the expected parity. That value is the XOR of the data bits when `cfg_par_even`=1, and its inverse when `cfg_par_even`=0. A mismatch sets `rx_perr`.
- R4: With `cfg_par_en`=1 and `cfg_par_force`=1, the parity bit must equal the inverse of `cfg_par_even` (1 when it is 0, 0 when it is 1). Otherwise `rx_perr` is set.
- R5: With `cfg_par_en`=0, no parity bit is taken: the stop bit follows the last data bit, and `rx_perr` is 0.
- R6: `rx_ferr` is 1 exactly when the line is low at the middle of the first stop bit.
- R7: When start, data, parity and stop samples are all low, the character is reported with `rx_brk`=1, `rx_ferr`=1, `rx_perr`=0 and `rx_data`=00.
- R8: After a break, no new character is started until the line has been seen high on a tick.
- R9: A low pulse that has ended by the middle of the start bit is discarded, and no character is delivered.
- R10: Each received character raises `rx_valid` for exactly one clock cycle, during its first stop bit.
- R11: A character whose stop bit is followed at once by the next start bit is received correctly, and so is that next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling strobe, OSR per bit time |
| rx | input | 1 | Synchronized serial input, idle high |
| cfg_len | input | 2 | Data bit count code (00=5 to 11=8) |
| cfg_par_en | input | 1 | A parity bit follows the data |
| cfg_par_even | input | 1 | Even parity sense; also selects the forced level |
| cfg_par_force | input | 1 | Check parity against a fixed level |
| rx_valid | output | 1 | One-cycle strobe: character ready |
| rx_data | output | 8 | Right-aligned received data |
| rx_perr | output | 1 | Parity error tag |
| rx_ferr | output | 1 | Framing error tag |
| rx_brk | output | 1 | Break tag |

## Verification
Several properties are checked by assertions on every cycle:
- the valid strobe is never longer than one cycle;
- a break character always carries zero data and a framing tag;
- a short format leaves the upper data bits clear;
- a false start sends the sequencer back to hunting;
- with parity disabled, the last data bit leads straight into the stop bit;
- the post-break hold persists while the line is low.

Whether each parity mode, data length and stop level produces the right tags is shown only by the bench's scenarios. The same holds for a low glitch producing nothing and for back-to-back characters both arriving. The bench checks these by driving whole frames against a behavioural reference queue.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int MAX_BITS = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP,
        PH_HOLD
    } srx_phase_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_even;
        logic       par_force;
    } srx_cfg_t;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                perr;
        logic                ferr;
        logic                brk;
    } srx_char_t;

    // Index of the final data bit: code 00 -> 4, code 11 -> 7.
    function automatic logic [2:0] last_index(input logic [1:0] len);
        return {1'b1, len};
    endfunction

    // Parity level the line must carry; bits above the length are already zero.
    function automatic logic expected_parity(input srx_cfg_t c,
                                             input logic [MAX_BITS-1:0] d);
        if (c.par_force)
            return ~c.par_even;
        return c.par_even ? ^d : ~(^d);
    endfunction

endpackage

// File: rtl/srx_sequencer.sv
module srx_sequencer
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    input  logic [2:0] last_idx,
    input  logic       par_en,
    input  logic       all_low,
    output srx_phase_e phase,
    output logic [2:0] bit_idx,
    output logic       sample
);

    localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] MID_START = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] MID_BIT   = CW'(OSR - 1);

    logic [CW-1:0] cnt;
    logic          at_mid;
    logic          in_frame;

    assign in_frame = (phase == PH_START) || (phase == PH_DATA) ||
                      (phase == PH_PARITY) || (phase == PH_STOP);
    assign at_mid   = (phase == PH_START) ? (cnt == MID_START) : (cnt == MID_BIT);
    assign sample   = tick && in_frame && at_mid;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
        end else if (tick) begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (!rx) phase <= PH_START;
                end
                PH_HOLD: begin
                    cnt <= '0;
                    if (rx) phase <= PH_IDLE;
                end
                default: begin
                    if (!at_mid) begin
                        cnt <= cnt + 1'b1;
                    end else begin
                        cnt <= '0;
                        unique case (phase)
                            PH_START: begin
                                bit_idx <= '0;
                                phase   <= rx ? PH_IDLE : PH_DATA;
                            end
                            PH_DATA: begin
                                if (bit_idx == last_idx)
                                    phase <= par_en ? PH_PARITY : PH_STOP;
                                else
                                    bit_idx <= bit_idx + 1'b1;
                            end
                            PH_PARITY: phase <= PH_STOP;
                            default:   phase <= (all_low && !rx) ? PH_HOLD : PH_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_START && sample && rx) |=> (phase == PH_IDLE)); // R9

    AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && !rx) |=> (phase == PH_HOLD)); // R8

    AST_NO_PARITY_SLOT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && sample && bit_idx == last_idx && !par_en)
        |=> (phase == PH_STOP)); // R5

endmodule

// File: rtl/srx_assembler.sv
module srx_assembler
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx,
    input  logic       sample,
    input  srx_phase_e phase,
    input  logic [2:0] bit_idx,
    input  srx_cfg_t   cfg,
    output logic       all_low,
    output logic       out_valid,
    output srx_char_t  out_char
);

    logic [MAX_BITS-1:0] shreg;
    logic                par_bit;
    logic                is_break;

    assign is_break = all_low && !rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            par_bit   <= 1'b0;
            all_low   <= 1'b0;
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (sample) begin
                unique case (phase)
                    PH_START: begin
                        shreg   <= '0;
                        all_low <= 1'b1;
                    end
                    PH_DATA: begin
                        shreg[bit_idx] <= rx;
                        if (rx) all_low <= 1'b0;
                    end
                    PH_PARITY: begin
                        par_bit <= rx;
                        if (rx) all_low <= 1'b0;
                    end
                    PH_STOP: begin
                        out_valid     <= 1'b1;
                        out_char.data <= is_break ? '0 : shreg;
                        out_char.ferr <= !rx;
                        out_char.brk  <= is_break;
                        out_char.perr <= cfg.par_en && !is_break &&
                                         (par_bit != expected_parity(cfg, shreg));
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R10

    AST_BREAK_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_char.brk) |-> (out_char.data == '0 && !out_char.perr)); // R7

    AST_BREAK_HAS_FRAMING: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_char.brk) |-> out_char.ferr); // R7

    AST_NOPAR_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !cfg.par_en) |-> !out_char.perr); // R5

    AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cfg.len == 2'b00) |-> (out_char.data[7:5] == 3'b000)); // R2

endmodule

// File: rtl/serial_rx_tagger.sv
module serial_rx_tagger
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_par_force,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_brk
);

    srx_cfg_t   cfg;
    srx_char_t  chr;
    srx_phase_e phase;
    logic [2:0] bit_idx;
    logic       sample;
    logic       all_low;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_even: cfg_par_even,
                   par_force: cfg_par_force};

    srx_sequencer #(.OSR(OSR)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .rx       (rx),
        .last_idx (last_index(cfg_len)),
        .par_en   (cfg_par_en),
        .all_low  (all_low),
        .phase    (phase),
        .bit_idx  (bit_idx),
        .sample   (sample)
    );

    srx_assembler u_asm (
        .clk       (clk),
        .rst       (rst),
        .rx        (rx),
        .sample    (sample),
        .phase     (phase),
        .bit_idx   (bit_idx),
        .cfg       (cfg),
        .all_low   (all_low),
        .out_valid (rx_valid),
        .out_char  (chr)
    );

    assign rx_data = chr.data;
    assign rx_perr = chr.perr;
    assign rx_ferr = chr.ferr;
    assign rx_brk  = chr.brk;

endmodule

// File: tb/serial_rx_tagger_tb.sv
module serial_rx_tagger_tb;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_force = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_brk;

    typedef struct {
        logic [7:0] d;
        bit         p;
        bit         f;
        bit         b;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   div = 0;

    always #10 clk = ~clk;

    serial_rx_tagger u_dut (
        .clk(clk), .rst(rst), .tick(tick), .rx(rx),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_force(cfg_par_force), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    always @(negedge clk) begin
        tick <= (div == TICK_DIV - 1);
        div  <= (div == TICK_DIV - 1) ? 0 : div + 1;
    end

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    // Reference model: compares every clock against the queue of expected characters
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected rx_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rx_data == e.d, {e.tag, " data"}, rx_data, e.d);
                check(rx_perr == e.p, {e.tag, " perr"}, rx_perr, e.p);
                check(rx_ferr == e.f, {e.tag, " ferr"}, rx_ferr, e.f);
                check(rx_brk == e.b, {e.tag, " brk"}, rx_brk, e.b);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            errors++;
            $display("FAIL R10 watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit good_parity(input logic [7:0] d, input int nb);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += d[i];
        if (cfg_par_force) return !cfg_par_even;
        return cfg_par_even ? bit'(ones % 2) : !bit'(ones % 2);
    endfunction

    task automatic line_bit(input logic v);
        rx = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] d, input bit bad_par, input bit stop_v,
                         input bit idle_after, input string tag);
        int   nb;
        bit   pb;
        exp_t e;
        nb = 5 + int'(cfg_len);
        pb = good_parity(d, nb) ^ bad_par;
        e.d = d & 8'((1 << nb) - 1);
        e.p = cfg_par_en && bad_par;
        e.f = !stop_v;
        e.b = 1'b0;
        e.tag = tag;
        exp_q.push_back(e);
        line_bit(1'b0);
        for (int i = 0; i < nb; i++) line_bit(d[i]);
        if (cfg_par_en) line_bit(pb);
        line_bit(stop_v);
        check(exp_q.size() == 0, {tag, " delivered in stop bit"}, exp_q.size(), 0);
        if (idle_after) line_bit(1'b1);
    endtask

    task automatic set_cfg(input logic [1:0] l, input bit pe, input bit ev, input bit fo);
        cfg_len = l; cfg_par_en = pe; cfg_par_even = ev; cfg_par_force = fo;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(rx_valid == 1'b0, "R1 valid low in reset", rx_valid, 0);
        rst = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rx_valid) check(1'b0, "R1 valid after reset", 1, 0);
        end
        check(rx_valid == 1'b0, "R1 idle after reset", rx_valid, 0);
        line_bit(1'b1);

        // R2: all four lengths, no parity, upper bits driven high must not appear
        set_cfg(2'b11, 0, 0, 0);
        frame(8'hA5, 0, 1, 1, "R2 len8");
        set_cfg(2'b10, 0, 0, 0);
        frame(8'hFF, 0, 1, 1, "R2 len7");
        set_cfg(2'b01, 0, 0, 0);
        frame(8'hEA, 0, 1, 1, "R2 len6");
        set_cfg(2'b00, 0, 0, 0);
        frame(8'hF3, 0, 1, 1, "R2 len5");

        // R5: parity disabled, stop right after data
        set_cfg(2'b11, 0, 1, 0);
        frame(8'h3C, 0, 1, 1, "R5 nopar");

        // R3: even and odd, correct and wrong
        set_cfg(2'b11, 1, 1, 0);
        frame(8'h37, 0, 1, 1, "R3 even ok");
        frame(8'h37, 1, 1, 1, "R3 even bad");
        set_cfg(2'b11, 1, 0, 0);
        frame(8'h81, 0, 1, 1, "R3 odd ok");
        frame(8'h81, 1, 1, 1, "R3 odd bad");
        set_cfg(2'b00, 1, 0, 0);
        frame(8'h0B, 0, 1, 1, "R3 odd len5 ok");

        // R4: forced levels
        set_cfg(2'b11, 1, 0, 1);
        frame(8'h12, 0, 1, 1, "R4 forced1 ok");
        frame(8'h12, 1, 1, 1, "R4 forced1 bad");
        set_cfg(2'b11, 1, 1, 1);
        frame(8'h13, 0, 1, 1, "R4 forced0 ok");
        frame(8'h13, 1, 1, 1, "R4 forced0 bad");

        // R6: stop bit low
        set_cfg(2'b11, 0, 0, 0);
        frame(8'h5A, 0, 0, 1, "R6 framing");
        line_bit(1'b1);
        frame(8'h66, 0, 1, 1, "R6 recover");

        // R9: short low glitch
        rx = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rx = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check(exp_q.size() == 0, "R9 no char from glitch", exp_q.size(), 0);
        frame(8'hC3, 0, 1, 1, "R9 after glitch");

        // R11: back to back
        set_cfg(2'b11, 1, 1, 0);
        frame(8'h71, 0, 1, 0, "R11 first");
        frame(8'h8E, 0, 1, 1, "R11 second");

        // R7/R8: break with odd parity, held low long after the frame
        set_cfg(2'b11, 1, 0, 0);
        begin
            exp_t e;
            e.d = 8'h00; e.p = 0; e.f = 1; e.b = 1; e.tag = "R7 break";
            exp_q.push_back(e);
        end
        for (int i = 0; i < 12; i++) line_bit(1'b0);
        check(exp_q.size() == 0, "R7 break delivered", exp_q.size(), 0);
        for (int i = 0; i < 20; i++) line_bit(1'b0);
        check(exp_q.size() == 0, "R8 no extra char while low", exp_q.size(), 0);
        line_bit(1'b1);
        line_bit(1'b1);
        frame(8'h29, 0, 1, 1, "R8 char after break");

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule